// File: doc/BRIEF.md
# Unaligned Load Cell Sequencer

This block serves byte, halfword and word loads from a byte-addressed 32-bit address space. The memory behind it is built from 32-bit cells and split into eight modules that are selected by the high-order address bits. A request carries a base value, a signed 16-bit displacement, an access size and a flag that selects signed or unsigned extension. The block adds the base and the displacement to form the load address. It decides whether the access fits in one cell or straddles two, and names the module that holds each cell.

The memory port moves one cell per read. The block issues one strobe for each cell the access needs, collects the returned cells, and picks the requested bytes out of them in big-endian order. The value is then extended to 32 bits. Misaligned halfwords and words are legal. They may cross a cell boundary, a module boundary, or the top of the address space, where the address wraps to zero. One request is handled at a time. Requests and results each use a valid/ready handshake.

Top module: `ulc_load_seq`

## Requirements
- R1: The load address is `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32. The first read presents that address with bits [1:0] cleared on `mem_addr`.
- R2: On every read strobe, `mem_module` equals bits [31:29] of `mem_addr`. Each module holds 2^27 cells.
- R3: Size codes on `req_size` are 0 for byte, 1 for halfword, and 2 or 3 for word. With lo = address bits [1:0] and n the byte count, one cell is needed when lo + n - 1 is 3 or less, and two cells otherwise. A byte always needs one cell.
- R4: When two cells are needed, the second read address is the first plus 4, modulo 2^32. Its module is taken from that new address, so 0xFFFFFFFC is followed by 0x00000000 in module 0 and no error is raised.
- R5: In the cycle after a request is accepted, `plan_valid` is high for one cycle. In that cycle `plan_cells` holds the cell count, `plan_mod_first` holds the first module, and `plan_mod_second` holds the second module, which equals the first when only one cell is used.
- R6: `mem_rdata` is taken one cycle after its `mem_rd` strobe. Each request issues exactly as many strobes as it needs cells, and the strobes fall in consecutive cycles.
- R7: Bytes are big-endian. The byte at address offset 0 of a cell is bits [31:24]. Consecutive addresses fill the result from its most significant requested byte downwards, and the second cell continues after the first.
- R8: When `req_signed` is 1, the loaded byte or halfword is sign-extended. When it is 0, the value is zero-extended.
- R9: `req_ready` is high only while no request is in flight. `rsp_valid` stays high with `rsp_data` unchanged until `rsp_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_base | input | 32 | Base address value |
| req_offset | input | 16 | Signed displacement |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed | input | 1 | 1 sign-extends, 0 zero-extends |
| plan_valid | output | 1 | Access plan published |
| plan_cells | output | 2 | Cells touched (1 or 2) |
| plan_mod_first | output | 3 | Module of first cell |
| plan_mod_second | output | 3 | Module of second cell |
| mem_rd | output | 1 | Cell read strobe |
| mem_addr | output | 32 | Cell-aligned byte address |
| mem_module | output | 3 | Module addressed by this read |
| mem_rdata | input | 32 | Cell data, one cycle after strobe |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result consumed |
| rsp_data | output | 32 | Extended load result |

## Verification
A wrong cell count or module latched at acceptance shows up one cycle later on the plan outputs. The same fault then changes the number of read strobes and the result. A bad second-cell address or a wrong wrap shows up on `mem_addr` in the cycle right after the first strobe. Byte-lane or extension faults affect only `rsp_data`. They appear in the first cycle that `rsp_valid` is high, which comes two or three cycles after the plan, and they stay visible while the result is held under back-pressure.

// File: rtl/ulc_pkg.sv
package ulc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PLAN, ST_BEAT0, ST_BEAT1, ST_RESP
  } ulc_state_t;

  // byte count for a size code; codes 2 and 3 both mean a full word
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] eff_address(input logic [31:0] base,
                                              input logic [15:0] disp);
    return base + {{16{disp[15]}}, disp};
  endfunction

  // last byte lane touched beyond lane 3 means the access spills into a second cell
  function automatic logic [1:0] cells_touched(input logic [1:0] lane,
                                               input logic [2:0] nbytes);
    logic [2:0] last_lane;
    last_lane = {1'b0, lane} + nbytes - 3'd1;
    return (last_lane > 3'd3) ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/ulc_addr_plan.sv
module ulc_addr_plan #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int CELL_LOG2 = 27
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  disp,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] cell_first,
  output logic [ADDR_W-1:0] cell_second,
  output logic [1:0]        lane,
  output logic [1:0]        cells,
  output logic [ADDR_W-CELL_LOG2-3:0] mod_first,
  output logic [ADDR_W-CELL_LOG2-3:0] mod_second
);
  import ulc_pkg::*;
  localparam int MOD_BITS = ADDR_W - CELL_LOG2 - 2;

  logic [ADDR_W-1:0] ea;

  always_comb begin
    ea          = eff_address(base, disp);
    lane        = ea[1:0];
    cell_first  = {ea[ADDR_W-1:2], 2'b00};
    cell_second = cell_first + ADDR_W'(4);
    cells       = cells_touched(lane, size_bytes(size));
    mod_first   = cell_first[ADDR_W-1 -: MOD_BITS];
    mod_second  = (cells == 2'd2) ? cell_second[ADDR_W-1 -: MOD_BITS] : mod_first;
  end
endmodule

// File: rtl/ulc_assembler.sv
module ulc_assembler #(
  parameter int CELL_W = 32
) (
  input  logic [CELL_W-1:0] cell_a,
  input  logic [CELL_W-1:0] cell_b,
  input  logic [1:0]        lane,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [CELL_W-1:0] value
);
  localparam int PAIR_W = 2 * CELL_W;

  logic [PAIR_W-1:0] pair;
  logic [CELL_W-1:0] top;

  always_comb begin
    pair = {cell_a, cell_b} << {lane, 3'b000};
    top  = pair[PAIR_W-1 -: CELL_W];
    case (size)
      2'd0:    value = {{(CELL_W-8){sgn & top[CELL_W-1]}},  top[CELL_W-1 -: 8]};
      2'd1:    value = {{(CELL_W-16){sgn & top[CELL_W-1]}}, top[CELL_W-1 -: 16]};
      default: value = top;
    endcase
  end
endmodule

// File: rtl/ulc_load_seq.sv
module ulc_load_seq #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int CELL_LOG2 = 27,
  localparam int MOD_BITS = ADDR_W - CELL_LOG2 - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_base,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [1:0]          req_size,
  input  logic                req_signed,
  output logic                plan_valid,
  output logic [1:0]          plan_cells,
  output logic [MOD_BITS-1:0] plan_mod_first,
  output logic [MOD_BITS-1:0] plan_mod_second,
  output logic                mem_rd,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [MOD_BITS-1:0] mem_module,
  input  logic [31:0]         mem_rdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [31:0]         rsp_data
);
  import ulc_pkg::*;

  ulc_state_t state_q;

  logic [ADDR_W-1:0]   pf_first, pf_second;
  logic [1:0]          pf_lane, pf_cells;
  logic [MOD_BITS-1:0] pf_mod_a, pf_mod_b;

  logic [ADDR_W-1:0]   first_q, second_q;
  logic [1:0]          lane_q, cells_q, size_q;
  logic                sgn_q;
  logic [MOD_BITS-1:0] mod_a_q, mod_b_q;
  logic [31:0]         cell_a_q, cell_b_q;
  logic [1:0]          rd_seen_q;

  // named events
  logic accept_ev, beat0_ev, beat1_ev, deliver_ev;
  assign accept_ev  = (state_q == ST_IDLE) && req_valid;
  assign beat0_ev   = (state_q == ST_BEAT0);
  assign beat1_ev   = (state_q == ST_BEAT1);
  assign deliver_ev = (state_q == ST_RESP) && rsp_ready;

  ulc_addr_plan #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CELL_LOG2(CELL_LOG2)) plan_i (
    .base(req_base), .disp(req_offset), .size(req_size),
    .cell_first(pf_first), .cell_second(pf_second), .lane(pf_lane),
    .cells(pf_cells), .mod_first(pf_mod_a), .mod_second(pf_mod_b)
  );

  ulc_assembler #(.CELL_W(32)) asm_i (
    .cell_a(cell_a_q), .cell_b(cell_b_q), .lane(lane_q), .size(size_q),
    .sgn(sgn_q), .value(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      first_q   <= '0;
      second_q  <= '0;
      lane_q    <= '0;
      cells_q   <= 2'd1;
      size_q    <= '0;
      sgn_q     <= 1'b0;
      mod_a_q   <= '0;
      mod_b_q   <= '0;
      cell_a_q  <= '0;
      cell_b_q  <= '0;
      rd_seen_q <= '0;
    end else begin
      if (mem_rd) rd_seen_q <= rd_seen_q + 2'd1;
      case (state_q)
        ST_IDLE: if (accept_ev) begin
          first_q   <= pf_first;
          second_q  <= pf_second;
          lane_q    <= pf_lane;
          cells_q   <= pf_cells;
          size_q    <= req_size;
          sgn_q     <= req_signed;
          mod_a_q   <= pf_mod_a;
          mod_b_q   <= pf_mod_b;
          rd_seen_q <= '0;
          state_q   <= ST_PLAN;
        end
        ST_PLAN:  state_q <= ST_BEAT0;
        ST_BEAT0: begin
          cell_a_q <= mem_rdata;
          cell_b_q <= '0;
          state_q  <= (cells_q == 2'd2) ? ST_BEAT1 : ST_RESP;
        end
        ST_BEAT1: begin
          cell_b_q <= mem_rdata;
          state_q  <= ST_RESP;
        end
        ST_RESP:  if (deliver_ev) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready       = (state_q == ST_IDLE);
  assign plan_valid      = (state_q == ST_PLAN);
  assign plan_cells      = cells_q;
  assign plan_mod_first  = mod_a_q;
  assign plan_mod_second = mod_b_q;
  assign mem_rd          = plan_valid || (beat0_ev && cells_q == 2'd2);
  assign mem_addr        = beat0_ev ? second_q : first_q;
  assign mem_module      = beat0_ev ? mod_b_q : mod_a_q;
  assign rsp_valid       = (state_q == ST_RESP);

  // assertions
  a_r2_module_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_module == mem_addr[ADDR_W-1 -: MOD_BITS]);
  a_r1_cell_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[1:0] == 2'b00);
  a_r3_byte_single_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (plan_valid && size_q == 2'd0) |-> plan_cells == 2'd1);
  a_r4_second_cell_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> mem_addr == $past(mem_addr) + ADDR_W'(4));
  a_r5_plan_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> plan_valid);
  a_r6_read_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> rd_seen_q == plan_cells);
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    plan_valid |-> !req_ready);
endmodule

// File: tb/ulc_load_seq_tb.sv
module ulc_load_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic        plan_valid;
  logic [1:0]  plan_cells;
  logic [2:0]  plan_mod_first, plan_mod_second;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic [2:0]  mem_module;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ulc_load_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_offset(req_offset), .req_size(req_size),
    .req_signed(req_signed), .plan_valid(plan_valid), .plan_cells(plan_cells),
    .plan_mod_first(plan_mod_first), .plan_mod_second(plan_mod_second),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_module(mem_module),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  // memory model: lane 0 always has bit 7 set, lane 1 never does
  function automatic logic [31:0] cell_val(input logic [31:0] a);
    return {1'b1, a[8:2], 1'b0, a[15:9], a[23:16], a[31:24] ^ a[9:2]};
  endfunction

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    logic [31:0] c;
    c = cell_val({a[31:2], 2'b00});
    case (a[1:0])
      2'd0: return c[31:24];
      2'd1: return c[23:16];
      2'd2: return c[15:8];
      default: return c[7:0];
    endcase
  endfunction

  logic [31:0] rd_total = 0;
  logic [31:0] rd_addr_log [4];
  logic [2:0]  rd_mod_log  [4];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= cell_val(mem_addr);
    if (rst_n && mem_rd) begin
      rd_addr_log[rd_total[1:0]] <= mem_addr;
      rd_mod_log[rd_total[1:0]]  <= mem_module;
      rd_total <= rd_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // one load, checked end to end; hold = cycles of response back-pressure
  task automatic run_load(input logic [31:0] base, input logic [15:0] off,
                          input logic [1:0] size, input bit sgn, input int hold);
    logic [31:0] ea, a0, a1, expv, got;
    int nb, cells, start, waited;
    ea = base + {{16{off[15]}}, off};
    nb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    cells = (int'(ea[1:0]) + nb > 4) ? 2 : 1;
    a0 = ea & 32'hFFFF_FFFC;
    a1 = a0 + 32'd4;
    expv = '0;
    for (int i = 0; i < nb; i++) expv = (expv << 8) | {24'd0, byte_at(ea + i)};
    if (sgn && nb == 1 && expv[7])  expv |= 32'hFFFF_FF00;
    if (sgn && nb == 2 && expv[15]) expv |= 32'hFFFF_0000;

    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready when idle", {31'd0, req_ready}, 32'd1);
    start = int'(rd_total);
    req_base = base; req_offset = off; req_size = size; req_signed = sgn;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(plan_valid == 1'b1, "R5 plan one cycle after accept", {31'd0, plan_valid}, 32'd1);
    chk(plan_cells == 2'(cells), "R3 cell count", {30'd0, plan_cells}, cells);
    chk(plan_mod_first == a0[31:29], "R2 first module", {29'd0, plan_mod_first}, {29'd0, a0[31:29]});
    chk(plan_mod_second == ((cells == 2) ? a1[31:29] : a0[31:29]), "R4 second module",
        {29'd0, plan_mod_second}, {29'd0, (cells == 2) ? a1[31:29] : a0[31:29]});
    waited = 0;
    while (!rsp_valid && waited < 10) begin
      @(negedge clk);
      waited++;
      if (!rsp_valid)
        chk(req_ready == 1'b0, "R9 no second request in flight", {31'd0, req_ready}, 32'd0);
    end
    chk(rsp_valid == 1'b1, "R6 response arrives", {31'd0, rsp_valid}, 32'd1);
    chk(int'(rd_total) - start == cells, "R6 strobe count", rd_total - start, cells);
    chk(rd_addr_log[start[1:0]] == a0, "R1 first cell address", rd_addr_log[start[1:0]], a0);
    chk(rd_mod_log[start[1:0]] == a0[31:29], "R2 first strobe module",
        {29'd0, rd_mod_log[start[1:0]]}, {29'd0, a0[31:29]});
    if (cells == 2) begin
      chk(rd_addr_log[2'(start + 1)] == a1, "R4 second cell address", rd_addr_log[2'(start + 1)], a1);
      chk(rd_mod_log[2'(start + 1)] == a1[31:29], "R4 second strobe module",
          {29'd0, rd_mod_log[2'(start + 1)]}, {29'd0, a1[31:29]});
    end
    chk(rsp_data == expv, (nb == 4) ? "R7 word assembly" : "R8 extended assembly", rsp_data, expv);
    got = rsp_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == got, "R9 result held", rsp_data, got);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R9 response retired", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R9 reset ready", {31'd0, req_ready}, 32'd1);
    chk(plan_valid == 1'b0 && mem_rd == 1'b0 && rsp_valid == 1'b0, "R5 reset quiet",
        {29'd0, plan_valid, mem_rd, rsp_valid}, 32'd0);
  endtask

  task automatic t_aligned_word();    run_load(32'h1000_0100, 16'd8, 2'd2, 1'b0, 0); endtask  // R7
  task automatic t_byte_signed();     run_load(32'hB003_D8E0, 16'd45, 2'd0, 1'b1, 0); endtask // R3 R8
  task automatic t_byte_lane0();      run_load(32'hB003_D8E0, 16'd0, 2'd0, 1'b1, 0); endtask  // R8 negative
  task automatic t_byte_unsigned();   run_load(32'hB003_D8E0, 16'd0, 2'd0, 1'b0, 0); endtask  // R8
  task automatic t_half_in_cell();    run_load(32'hB003_D8E0, 16'd45, 2'd1, 1'b1, 0); endtask // R3
  task automatic t_half_split();      run_load(32'h2000_0003, 16'd0, 2'd1, 1'b1, 0); endtask  // R4 R7
  task automatic t_word_split();      run_load(32'hB003_D8E0, 16'd54, 2'd2, 1'b0, 2); endtask // R4 R9
  task automatic t_negative_offset(); run_load(32'hC000_0035, 16'hFFCA, 2'd2, 1'b0, 0); endtask // R1 R4
  task automatic t_top_wrap();        run_load(32'hFFFF_FFFE, 16'd0, 2'd3, 1'b0, 1); endtask  // R4
  task automatic t_half_wrap();       run_load(32'hFFFF_FFFF, 16'd0, 2'd1, 1'b0, 0); endtask  // R4 R8

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned_word();
    t_byte_signed();
    t_byte_lane0();
    t_byte_unsigned();
    t_half_in_cell();
    t_half_split();
    t_word_split();
    t_negative_offset();
    t_top_wrap();
    t_half_wrap();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule